// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Engine

This block is the sending side of a serial port. It works in two ways. In asynchronous mode it produces framed characters on a single line that idles high. In synchronous mode it shifts plain data bits out alongside a clock. In synchronous mode the block either generates that clock itself from a baud-rate tick, or follows a clock that arrives from outside. A host configures the block through a small control register. It then writes characters, one byte at a time, into a holding register. From there the block moves each byte into a shift register and sends it out.

The baud-rate tick is an input strobe, one clock wide. The block counts sixteen ticks for each asynchronous bit. In synchronous master mode, one tick raises the generated clock and the next tick lowers it. The block also has two receive-enable inputs from a companion receiver. In synchronous mode, when either of them is active, transmission is blocked. An external clock for slave operation is taken as already synchronous to the system clock. The block detects its falling edges by comparing it with its value one cycle earlier.

Top module: `usart_tx_engine`

## Requirements
- R1: After reset the enable, synchronous, master and 9-bit fields read 0, the empty flag reads 1, `bufFull` is 0, `dataOut` is 1 and `clkOut` is 0.
- R2: `ctrlRead` returns the fields at these bit positions: enable at bit 0, synchronous at bit 1, master at bit 2, 9-bit at bit 3, ninth data at bit 4, empty at bit 5 (read only). Bits 7:6 always read 0.
- R3: In asynchronous mode (bit 1 = 0) a frame is sent as follows. First a 0 start bit. Then the data byte, least significant bit first. Then a 1 stop bit. Each bit lasts 16 baud ticks, and the line stays at 1 while idle.
- R4: With bit 3 set, the ninth data bit (bit 4) is sent after bit 7 of the data. In asynchronous mode it comes before the stop bit; in synchronous mode it is the last bit of the transfer.
- R5: A write to the holding register sets `bufFull`. The byte moves into the shifter, and `bufFull` clears, on the cycle the shifter is idle or finishes its last bit. A second queued byte therefore follows the first with no idle bit between them.
- R6: The empty flag is 0 while the shifter is sending and 1 otherwise. It can fall only when a byte was waiting in the holding register.
- R7: In synchronous master mode `clkOutEn` is 1 and `clkOut` idles low. A baud tick raises `clkOut`, and the next baud tick lowers it. The data shifts to the next bit at each fall. 8 or 9 bits are sent, with no start or stop bit.
- R8: In synchronous slave mode (bit 2 = 0) `clkOutEn` and `clkOut` stay 0. The data shifts to the next bit one cycle after each falling edge of `extClkIn`.
- R9: In asynchronous mode the master bit has no effect: `clkOut` stays 0, `clkOutEn` stays 0 and the frame timing is unchanged.
- R10: Clearing the enable bit aborts any transfer on the next cycle: `dataOut` returns to 1, `clkOut` to 0 and the empty flag to 1. A byte still waiting in the holding register is kept, and it is sent once the block is enabled again.
- R11: In synchronous mode, while `rxSingleEn` or `rxContEn` is 1, nothing is sent and a waiting byte stays in the holding register. The byte is sent once both inputs are 0.
- R12: In asynchronous mode `rxSingleEn` and `rxContEn` have no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle baud-rate strobe |
| ctrlWrite | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 5 | Control write data: ninth bit, 9-bit, master, synchronous, enable (bit 4 down to bit 0) |
| holdWrite | input | 1 | Write strobe for the holding register |
| holdData | input | DATA_W | Byte to send |
| rxSingleEn | input | 1 | Single-receive enable from the receiver |
| rxContEn | input | 1 | Continuous-receive enable from the receiver |
| extClkIn | input | 1 | External shift clock for slave mode |
| ctrlRead | output | 8 | Control and status read-back |
| emptyFlag | output | 1 | Shift register empty |
| bufFull | output | 1 | Holding register occupied |
| dataOut | output | 1 | Serial data line |
| clkOut | output | 1 | Generated synchronous clock |
| clkOutEn | output | 1 | Drive enable for the clock pin (master mode) |

## Verification
The checker monitors the following on every cycle:
- an idle shifter keeps the line high and the generated clock low;
- a holding write always leaves the buffer marked full;
- the empty flag falls only when a byte was waiting;
- a disable, or a receive override in synchronous mode, empties the shifter on the next cycle;
- no clock is driven in slave or asynchronous mode.

Bit order, frame length, sixteen-tick bit timing, ninth-bit placement, back-to-back chaining and falling-edge shifting can only be shown by the bench. Its queue-based model follows each frame bit by bit under each mode.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

  // Control field positions in the read-back word
  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_SYNC   = 1;
  localparam int unsigned CTRL_MASTER = 2;
  localparam int unsigned CTRL_WIDE   = 3;
  localparam int unsigned CTRL_NINTH  = 4;
  localparam int unsigned CTRL_EMPTY  = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;      // force shifter to idle (all ones)
    logic load;       // take holding byte into shifter
    logic shift;      // advance to next bit
    logic asyncFrame; // wrap data in start/stop bits on load
    logic wide;       // include the ninth bit on load
    logic ninth;      // value of the ninth bit
  } txStrobe_t;

endpackage

// File: rtl/usart_tx_datapath.sv
module usart_tx_datapath
  import usart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdWrite,
  input  logic [DATA_W-1:0] holdData,
  input  txStrobe_t         stb,
  output logic              dataOut
);

  localparam int unsigned FRAME_W = DATA_W + 3;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] loadWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (holdWrite) begin
      holdReg <= holdData;
    end
  end

  // Frame image: bit 0 leaves first; unused upper positions stay high
  always_comb begin
    loadWord = '1;
    if (stb.asyncFrame) begin
      loadWord[0] = 1'b0;
      for (int i = 0; i < int'(DATA_W); i++) begin
        loadWord[i+1] = holdReg[i];
      end
      if (stb.wide) loadWord[DATA_W+1] = stb.ninth;
    end else begin
      for (int i = 0; i < int'(DATA_W); i++) begin
        loadWord[i] = holdReg[i];
      end
      if (stb.wide) loadWord[DATA_W] = stb.ninth;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (stb.clear) begin
      shiftReg <= '1;
    end else if (stb.load) begin
      shiftReg <= loadWord;
    end else if (stb.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign dataOut = shiftReg[0];

endmodule

// File: rtl/usart_tx_control.sv
module usart_tx_control
  import usart_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       ctrlWrite,
  input  logic [4:0] ctrlWrData,
  input  logic       holdWrite,
  input  logic       rxSingleEn,
  input  logic       rxContEn,
  input  logic       extClkIn,
  output txStrobe_t  stb,
  output logic [7:0] ctrlRead,
  output logic       busy,
  output logic       bufFull,
  output logic       clkReg,
  output logic       clkDriveEn
);

  localparam int unsigned TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned BIT_W  = $clog2(DATA_W + 4);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);

  logic enReg, syncReg, masterReg, wideReg, ninthReg;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitsLeft;
  logic [BIT_W-1:0]  frameBits;
  logic extPrev;
  logic txActive, extFall, bitEnd, shiftNow, lastBit, loadNow;

  // Receive enables win over transmit enable in synchronous mode only
  assign txActive = enReg && !(syncReg && (rxSingleEn || rxContEn));
  assign extFall  = extPrev && !extClkIn;

  always_comb begin
    if (!syncReg)       bitEnd = baudTick && (tickCnt == TICK_LAST);
    else if (masterReg) bitEnd = baudTick && clkReg;
    else                bitEnd = extFall;
  end

  assign shiftNow  = busy && bitEnd;
  assign lastBit   = shiftNow && (bitsLeft == BIT_W'(1));
  assign loadNow   = txActive && bufFull && (!busy || lastBit);
  assign frameBits = BIT_W'(DATA_W) + (syncReg ? BIT_W'(0) : BIT_W'(2)) + BIT_W'(wideReg);

  always_comb begin
    stb            = '0;
    stb.clear      = !txActive;
    stb.load       = loadNow;
    stb.shift      = shiftNow && txActive;
    stb.asyncFrame = !syncReg;
    stb.wide       = wideReg;
    stb.ninth      = ninthReg;
  end

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      syncReg   <= 1'b0;
      masterReg <= 1'b0;
      wideReg   <= 1'b0;
      ninthReg  <= 1'b0;
    end else if (ctrlWrite) begin
      enReg     <= ctrlWrData[CTRL_EN];
      syncReg   <= ctrlWrData[CTRL_SYNC];
      masterReg <= ctrlWrData[CTRL_MASTER];
      wideReg   <= ctrlWrData[CTRL_WIDE];
      ninthReg  <= ctrlWrData[CTRL_NINTH];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
    end else if (holdWrite) begin
      bufFull <= 1'b1;
    end else if (loadNow) begin
      bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extClkIn;
  end

  // Shift sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      tickCnt  <= '0;
      bitsLeft <= '0;
      clkReg   <= 1'b0;
    end else if (!txActive) begin
      busy     <= 1'b0;
      tickCnt  <= '0;
      bitsLeft <= '0;
      clkReg   <= 1'b0;
    end else if (loadNow) begin
      busy     <= 1'b1;
      tickCnt  <= '0;
      bitsLeft <= frameBits;
      clkReg   <= 1'b0;
    end else if (busy) begin
      if (!syncReg && baudTick) begin
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + TICK_W'(1);
      end
      if (syncReg && masterReg && baudTick) begin
        clkReg <= !clkReg;
      end
      if (shiftNow) begin
        bitsLeft <= bitsLeft - BIT_W'(1);
        if (lastBit) busy <= 1'b0;
      end
    end
  end

  assign clkDriveEn = syncReg && masterReg;
  assign ctrlRead   = {2'b00, !busy, ninthReg, wideReg, masterReg, syncReg, enReg};

endmodule

// File: rtl/usart_tx_engine.sv
module usart_tx_engine
  import usart_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              ctrlWrite,
  input  logic [4:0]        ctrlWrData,
  input  logic              holdWrite,
  input  logic [DATA_W-1:0] holdData,
  input  logic              rxSingleEn,
  input  logic              rxContEn,
  input  logic              extClkIn,
  output logic [7:0]        ctrlRead,
  output logic              emptyFlag,
  output logic              bufFull,
  output logic              dataOut,
  output logic              clkOut,
  output logic              clkOutEn
);

  txStrobe_t stb;
  logic busy;

  usart_tx_control #(
    .DATA_W       (DATA_W),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .ctrlWrite (ctrlWrite),
    .ctrlWrData(ctrlWrData),
    .holdWrite (holdWrite),
    .rxSingleEn(rxSingleEn),
    .rxContEn  (rxContEn),
    .extClkIn  (extClkIn),
    .stb       (stb),
    .ctrlRead  (ctrlRead),
    .busy      (busy),
    .bufFull   (bufFull),
    .clkReg    (clkOut),
    .clkDriveEn(clkOutEn)
  );

  usart_tx_datapath #(
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .holdWrite(holdWrite),
    .holdData (holdData),
    .stb      (stb),
    .dataOut  (dataOut)
  );

  assign emptyFlag = !busy;

endmodule

// File: rtl/usart_tx_checker.sv
module usart_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       holdWrite,
  input logic       rxSingleEn,
  input logic       rxContEn,
  input logic [7:0] ctrlRead,
  input logic       emptyFlag,
  input logic       bufFull,
  input logic       dataOut,
  input logic       clkOut,
  input logic       clkOutEn
);

  p_idle_line_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> dataOut);

  p_clk_low_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> !clkOut);

  p_hold_sets_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    holdWrite |=> bufFull);

  p_load_needs_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(emptyFlag) |-> $past(bufFull));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRead[0] |=> emptyFlag);

  p_rx_override_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRead[1] && (rxSingleEn || rxContEn)) |=> emptyFlag);

  p_slave_no_clock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRead[1] && !ctrlRead[2]) |-> (!clkOutEn && !clkOut));

  p_async_clock_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRead[1] |-> (!clkOutEn && !clkOut));

endmodule

bind usart_tx_engine usart_tx_checker i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .holdWrite (holdWrite),
  .rxSingleEn(rxSingleEn),
  .rxContEn  (rxContEn),
  .ctrlRead  (ctrlRead),
  .emptyFlag (emptyFlag),
  .bufFull   (bufFull),
  .dataOut   (dataOut),
  .clkOut    (clkOut),
  .clkOutEn  (clkOutEn)
);

// File: tb/test_usart_tx_engine.sv
module test_usart_tx_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int TICKS      = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic ctrlWrite = 1'b0;
  logic [4:0] ctrlWrData = '0;
  logic holdWrite = 1'b0;
  logic [DATA_W-1:0] holdData = '0;
  logic rxSingleEn = 1'b0;
  logic rxContEn = 1'b0;
  logic extClkIn = 1'b0;
  logic [7:0] ctrlRead;
  logic emptyFlag, bufFull, dataOut, clkOut, clkOutEn;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit tickOn = 0;
  bit extOn = 0;
  bit ninthKnown = 0;
  int tickDiv = 0;
  int extDiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_tx_engine #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS)) i_usart_tx_engine (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .ctrlWrite(ctrlWrite),
    .ctrlWrData(ctrlWrData), .holdWrite(holdWrite), .holdData(holdData),
    .rxSingleEn(rxSingleEn), .rxContEn(rxContEn), .extClkIn(extClkIn),
    .ctrlRead(ctrlRead), .emptyFlag(emptyFlag), .bufFull(bufFull),
    .dataOut(dataOut), .clkOut(clkOut), .clkOutEn(clkOutEn)
  );

  // Reference model state
  bit mEn, mSync, mMaster, mWide, mNinth;
  bit mBusy, mClk, mBufFull, mExtPrev;
  int mTick;
  logic [DATA_W-1:0] mHold;
  bit q[$];

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // Stimulus generators for baud tick and external clock
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    baudTick = tickOn && (tickDiv == 0);
    tickDiv = (tickDiv + 1) % 2;
    if (extOn) begin
      extDiv = (extDiv + 1) % 3;
      if (extDiv == 0) extClkIn = ~extClkIn;
    end else begin
      extClkIn = 1'b0;
    end
  end

  // Behavioural model, stepped on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mSync = 0; mMaster = 0; mWide = 0; mNinth = 0;
      mBusy = 0; mClk = 0; mBufFull = 0; mExtPrev = 0; mTick = 0;
      mHold = '0; q.delete();
    end else begin
      bit act, fall, hit;
      act = mEn && !(mSync && (rxSingleEn || rxContEn));
      fall = mExtPrev && !extClkIn;
      mExtPrev = extClkIn;
      hit = 0;
      if (!act) begin
        q.delete(); mBusy = 0; mClk = 0; mTick = 0;
      end else if (mBusy) begin
        if (!mSync) begin
          if (baudTick) begin
            mTick++;
            if (mTick == TICKS) begin mTick = 0; hit = 1; end
          end
        end else if (mMaster) begin
          if (baudTick) begin
            if (!mClk) mClk = 1;
            else begin mClk = 0; hit = 1; end
          end
        end else if (fall) begin
          hit = 1;
        end
        if (hit) begin
          void'(q.pop_front());
          if (q.size() == 0) mBusy = 0;
        end
      end
      if (act && mBufFull && !mBusy) begin
        if (!mSync) q.push_back(1'b0);
        for (int i = 0; i < DATA_W; i++) q.push_back(mHold[i]);
        if (mWide) q.push_back(mNinth);
        if (!mSync) q.push_back(1'b1);
        mBusy = 1; mTick = 0; mClk = 0; mBufFull = 0;
      end
      if (holdWrite) begin mHold = holdData; mBufFull = 1; end
      if (ctrlWrite) begin
        mEn = ctrlWrData[0]; mSync = ctrlWrData[1]; mMaster = ctrlWrData[2];
        mWide = ctrlWrData[3]; mNinth = ctrlWrData[4];
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] expRead;
      logic [7:0] mask;
      expRead = {2'b00, !mBusy, mNinth, mWide, mMaster, mSync, mEn};
      mask = ninthKnown ? 8'hFF : 8'hEF;
      check({curReq, " dataOut"}, dataOut, (q.size() > 0) ? q[0] : 1'b1);
      check({curReq, " clkOut"}, clkOut, mClk);
      check({curReq, " clkOutEn"}, clkOutEn, mSync && mMaster);
      check({curReq, " emptyFlag"}, emptyFlag, !mBusy);
      check({curReq, " bufFull"}, bufFull, mBufFull);
      check({curReq, " ctrlRead"}, ctrlRead & mask, expRead & mask);
    end
  end

  task automatic writeCtrl(logic [4:0] v);
    @(posedge clk); #(CLK_PERIOD/4);
    ctrlWrite = 1'b1; ctrlWrData = v;
    @(posedge clk); #(CLK_PERIOD/4);
    ctrlWrite = 1'b0;
    ninthKnown = 1;
  endtask

  task automatic writeHold(logic [DATA_W-1:0] v);
    @(posedge clk); #(CLK_PERIOD/4);
    holdWrite = 1'b1; holdData = v;
    @(posedge clk); #(CLK_PERIOD/4);
    holdWrite = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (emptyFlag && !bufFull) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dataOut", dataOut, 1'b1);
    check("R1 emptyFlag", emptyFlag, 1'b1);
    check("R1 clkOut", clkOut, 1'b0);
    check("R1 bufFull", bufFull, 1'b0);
    check("R1 ctrlRead", ctrlRead & 8'hEF, 8'h20);

    // R2 field layout and unused bits
    curReq = "R2";
    writeCtrl(5'h1F);
    @(negedge clk);
    check("R2 ctrlRead all fields", ctrlRead, 8'h3F);
    writeCtrl(5'h00);
    @(negedge clk);
    check("R2 ctrlRead cleared", ctrlRead, 8'h20);

    // R3 async 8-bit frame
    tickOn = 1;
    curReq = "R3";
    writeCtrl(5'h01);
    writeHold(8'hA5);
    repeat (60) @(negedge clk);
    check("R6 emptyFlag during frame", emptyFlag, 1'b0);
    waitIdle();

    // R4 async 9-bit frames, ninth bit 1 then 0
    curReq = "R4";
    writeCtrl(5'h19);
    writeHold(8'h3C);
    waitIdle();
    writeCtrl(5'h09);
    writeHold(8'hC3);
    waitIdle();

    // R5 / R6 back-to-back
    curReq = "R5";
    writeCtrl(5'h01);
    writeHold(8'h11);
    writeHold(8'h22);
    @(negedge clk);
    check("R5 bufFull after second write", bufFull, 1'b1);
    curReq = "R6";
    waitIdle();

    // R9 master bit ignored in async
    curReq = "R9";
    writeCtrl(5'h05);
    writeHold(8'h5A);
    waitIdle();

    // R12 receive enables ignored in async
    curReq = "R12";
    writeCtrl(5'h01);
    rxContEn = 1'b1;
    writeHold(8'h96);
    repeat (40) @(negedge clk);
    check("R12 emptyFlag busy with rx enable", emptyFlag, 1'b0);
    waitIdle();
    rxContEn = 1'b0;

    // R7 sync master 8-bit then 9-bit back-to-back
    curReq = "R7";
    writeCtrl(5'h07);
    writeHold(8'h6D);
    waitIdle();
    writeCtrl(5'h1F);
    writeHold(8'hB2);
    writeHold(8'h4B);
    waitIdle();

    // R8 sync slave on external clock
    curReq = "R8";
    tickOn = 0;
    writeCtrl(5'h03);
    extOn = 1;
    writeHold(8'h4E);
    waitIdle();
    extOn = 0;
    tickOn = 1;

    // R11 receive override in sync mode
    curReq = "R11";
    writeCtrl(5'h07);
    rxSingleEn = 1'b1;
    writeHold(8'h81);
    repeat (40) @(negedge clk);
    check("R11 emptyFlag held", emptyFlag, 1'b1);
    check("R11 bufFull kept", bufFull, 1'b1);
    check("R11 dataOut idle", dataOut, 1'b1);
    rxSingleEn = 1'b0;
    waitIdle();

    // R10 abort on enable clear
    curReq = "R10";
    writeCtrl(5'h01);
    writeHold(8'hF0);
    repeat (100) @(negedge clk);
    writeHold(8'h0F);
    writeCtrl(5'h00);
    repeat (2) @(negedge clk);
    check("R10 emptyFlag after abort", emptyFlag, 1'b1);
    check("R10 dataOut after abort", dataOut, 1'b1);
    check("R10 bufFull kept", bufFull, 1'b1);
    writeCtrl(5'h01);
    waitIdle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule